// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits beside a UART and runs character-based flow control in both directions. On the receive side it compares each incoming character against four programmable codes: two "resume" codes and two "pause" codes. A matching pause code stops the local transmitter and a matching resume code lets it run again. Matched codes are removed from the receive stream, and every other character is passed through.

On the transmit side it watches the receive FIFO fill level. When the level climbs to the halt threshold it asks the transmitter to insert a pause code. When the level later drains to the resume threshold it asks for a resume code. Both thresholds are 4-bit fields counted in steps of 8 FIFO words. A 4-bit mode field picks, separately for each direction, which code pair is used: the first pair, the second pair or both pairs. A master enable gates all of this behaviour.

Top module: `sfc_xonxoff`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_pause`, `ins_req`, `det_flags` and `rxo_valid` are all 0.
- R2: Detection flags appear one cycle after a received character. Bit 0 is resume code 1, bit 1 is resume code 2, bit 2 is pause code 1 and bit 3 is pause code 2. `fc_mode[1]` enables comparison against the pair-1 codes and `fc_mode[0]` against the pair-2 codes. A disabled pair never flags.
- R3: A flagged pause code sets `tx_pause` on the next cycle and a flagged resume code clears it. Otherwise `tx_pause` holds its value.
- R4: A flagged character is dropped. Every other received character appears on `rxo_char` with `rxo_valid` one cycle later.
- R5: When not halted, a FIFO level of `halt_lvl*8` or more raises `ins_req` on the next cycle carrying a pause code. `fc_mode[3:2]` selects the code: 01 gives pause code 2, 10 gives pause code 1, 11 gives both. Mode 00 never requests.
- R6: After a halt, a FIFO level of `resume_lvl*8` or less requests the matching resume code or codes in the same way.
- R7: In mode 11 the pair-1 code is presented first. The pair-2 code follows on the cycle after the first is accepted.
- R8: `ins_req` and `ins_char` hold steady until `ins_ready` is seen. Only one sequence is issued per threshold crossing, even if the level stays beyond the threshold.
- R9: With `fc_enable` low, nothing is flagged, every character is forwarded, and on the next cycle `tx_pause` and `ins_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_enable | input | 1 | Master enable for software flow control |
| fc_mode | input | 4 | [1:0] receive compare select, [3:2] transmit insert select |
| halt_lvl | input | 4 | Halt threshold in units of 8 words |
| resume_lvl | input | 4 | Resume threshold in units of 8 words |
| xon1_code | input | 8 | Resume code, pair 1 |
| xon2_code | input | 8 | Resume code, pair 2 |
| xoff1_code | input | 8 | Pause code, pair 1 |
| xoff2_code | input | 8 | Pause code, pair 2 |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| fifo_level | input | LVL_W (8) | Receive FIFO fill level |
| ins_ready | input | 1 | Transmitter accepts the inserted code |
| tx_pause | output | 1 | Hold the local transmitter after its current frame |
| ins_req | output | 1 | Request to insert a flow-control code |
| ins_char | output | 8 | Code to insert |
| det_flags | output | 4 | One-cycle code-match flags |
| rxo_valid | output | 1 | Forwarded character strobe |
| rxo_char | output | 8 | Forwarded character |

## Verification
Every result is registered exactly once. The detection flags, the forwarded character and the pause change all appear one cycle after the received character. An insert request appears one cycle after the FIFO level crosses a threshold, and the second code of a two-code sequence appears one cycle after the first is accepted. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each reading lands in the single cycle in which the result is due. A pulse that shows up one cycle early or late is therefore caught. Request hold is checked over several cycles in which `ins_ready` stays low.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int CHAR_W    = 8;
    localparam int N_CODES   = 4;
    localparam int THR_W     = 4;
    localparam int THR_SHIFT = 3;

    localparam int IDX_ON1  = 0;
    localparam int IDX_ON2  = 1;
    localparam int IDX_OFF1 = 2;
    localparam int IDX_OFF2 = 3;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        char_t off2;
        char_t off1;
        char_t on2;
        char_t on1;
    } code_set_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FIRST,
        SQ_SECOND
    } seq_state_t;

    function automatic char_t code_at(input code_set_t c, input int idx);
        case (idx)
            IDX_ON1:  return c.on1;
            IDX_ON2:  return c.on2;
            IDX_OFF1: return c.off1;
            default:  return c.off2;
        endcase
    endfunction

    function automatic bit is_pair1(input int idx);
        return (idx == IDX_ON1) || (idx == IDX_OFF1);
    endfunction
endpackage

// File: rtl/sfc_rx_filter.sv
module sfc_rx_filter
    import sfc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [1:0]           cmp_sel,
    input  code_set_t            codes,
    input  logic                 rx_valid,
    input  char_t                rx_char,
    output logic                 pause,
    output logic [N_CODES-1:0]   det,
    output logic                 out_valid,
    output char_t                out_char
);
    logic [N_CODES-1:0] hit;

    for (genvar k = 0; k < N_CODES; k++) begin : g_cmp
        localparam bit P1 = is_pair1(k);
        assign hit[k] = en && rx_valid && (P1 ? cmp_sel[1] : cmp_sel[0])
                        && (rx_char == code_at(codes, k));
    end

    logic hit_off, hit_on;
    assign hit_off = hit[IDX_OFF1] | hit[IDX_OFF2];
    assign hit_on  = hit[IDX_ON1]  | hit[IDX_ON2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pause     <= 1'b0;
            det       <= '0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            det       <= hit;
            out_valid <= rx_valid && (hit == '0);
            if (rx_valid) out_char <= rx_char;
            if (!en)          pause <= 1'b0;
            else if (hit_off) pause <= 1'b1;
            else if (hit_on)  pause <= 1'b0;
        end
    end
endmodule

// File: rtl/sfc_tx_seq.sv
module sfc_tx_seq
    import sfc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        gen_sel,
    input  code_set_t         codes,
    input  logic [THR_W-1:0]  halt_lvl,
    input  logic [THR_W-1:0]  resume_lvl,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              ready,
    output logic              req,
    output char_t             code
);
    localparam int SCALED_W = THR_W + THR_SHIFT;

    logic [LVL_W-1:0] halt_thr, resume_thr;
    assign halt_thr   = LVL_W'({halt_lvl,   {THR_SHIFT{1'b0}}});
    assign resume_thr = LVL_W'({resume_lvl, {THR_SHIFT{1'b0}}});

    seq_state_t state;
    logic       halted;
    logic       send_on;
    logic       both;
    logic       start_off, start_on;

    assign both      = gen_sel[1] & gen_sel[0];
    assign start_off = en && (gen_sel != 2'b00) && !halted && (fifo_level >= halt_thr);
    assign start_on  = en && (gen_sel != 2'b00) &&  halted && (fifo_level <= resume_thr);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= SQ_IDLE;
            halted  <= 1'b0;
            send_on <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_off) begin
                        state   <= SQ_FIRST;
                        halted  <= 1'b1;
                        send_on <= 1'b0;
                    end else if (start_on) begin
                        state   <= SQ_FIRST;
                        halted  <= 1'b0;
                        send_on <= 1'b1;
                    end
                end
                SQ_FIRST:  if (ready) state <= both ? SQ_SECOND : SQ_IDLE;
                SQ_SECOND: if (ready) state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    logic use_p1;
    assign use_p1 = (state == SQ_FIRST) && gen_sel[1];
    assign req    = (state != SQ_IDLE);

    always_comb begin
        if (use_p1) code = send_on ? codes.on1 : codes.off1;
        else        code = send_on ? codes.on2 : codes.off2;
    end

    logic unused_w;
    assign unused_w = ^SCALED_W;
endmodule

// File: rtl/sfc_xonxoff.sv
module sfc_xonxoff
    import sfc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fc_enable,
    input  logic [3:0]        fc_mode,
    input  logic [THR_W-1:0]  halt_lvl,
    input  logic [THR_W-1:0]  resume_lvl,
    input  logic [CHAR_W-1:0] xon1_code,
    input  logic [CHAR_W-1:0] xon2_code,
    input  logic [CHAR_W-1:0] xoff1_code,
    input  logic [CHAR_W-1:0] xoff2_code,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              ins_ready,
    output logic              tx_pause,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char,
    output logic [N_CODES-1:0] det_flags,
    output logic              rxo_valid,
    output logic [CHAR_W-1:0] rxo_char
);
    code_set_t codes;
    assign codes = '{off2: xoff2_code, off1: xoff1_code, on2: xon2_code, on1: xon1_code};

    sfc_rx_filter u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (fc_enable),
        .cmp_sel   (fc_mode[1:0]),
        .codes     (codes),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .pause     (tx_pause),
        .det       (det_flags),
        .out_valid (rxo_valid),
        .out_char  (rxo_char)
    );

    sfc_tx_seq #(.LVL_W(LVL_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .en         (fc_enable),
        .gen_sel    (fc_mode[3:2]),
        .codes      (codes),
        .halt_lvl   (halt_lvl),
        .resume_lvl (resume_lvl),
        .fifo_level (fifo_level),
        .ready      (ins_ready),
        .req        (ins_req),
        .code       (ins_char)
    );
endmodule

// File: rtl/sfc_xonxoff_chk.sv
module sfc_xonxoff_chk (
    input logic       clk,
    input logic       rst,
    input logic       fc_enable,
    input logic       rx_valid,
    input logic       ins_ready,
    input logic       tx_pause,
    input logic       ins_req,
    input logic [7:0] ins_char,
    input logic [3:0] det_flags,
    input logic       rxo_valid
);
    p_det_cause_r2: assert property (@(posedge clk) disable iff (rst)
        (det_flags != 4'b0) |-> $past(rx_valid));

    p_pause_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pause) |-> $past(rx_valid) && $past(fc_enable));

    p_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (det_flags != 4'b0) |-> !rxo_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ins_req && !ins_ready && fc_enable) |=> ins_req && $stable(ins_char));

    p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !fc_enable |=> !tx_pause && !ins_req);
endmodule

bind sfc_xonxoff sfc_xonxoff_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fc_enable (fc_enable),
    .rx_valid  (rx_valid),
    .ins_ready (ins_ready),
    .tx_pause  (tx_pause),
    .ins_req   (ins_req),
    .ins_char  (ins_char),
    .det_flags (det_flags),
    .rxo_valid (rxo_valid)
);

// File: tb/sim_sfc_xonxoff.sv
module sim_sfc_xonxoff;
    logic       clk = 0;
    logic       rst = 1;
    logic       fc_enable = 0;
    logic [3:0] fc_mode = 0;
    logic [3:0] halt_lvl = 4, resume_lvl = 1;
    logic [7:0] xon1_code = 8'h11, xon2_code = 8'h12, xoff1_code = 8'h13, xoff2_code = 8'h14;
    logic       rx_valid = 0;
    logic [7:0] rx_char = 0;
    logic [7:0] fifo_level = 0;
    logic       ins_ready = 0;
    logic       tx_pause, ins_req, rxo_valid;
    logic [7:0] ins_char, rxo_char;
    logic [3:0] det_flags;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sfc_xonxoff u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code_of(input int i);
        case (i)
            0: return xon1_code;
            1: return xon2_code;
            2: return xoff1_code;
            3: return xoff2_code;
            default: return 8'h41;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit exp_pause;
        repeat (3) @(negedge clk);
        chk("R1 pause", tx_pause, 0);
        chk("R1 req", ins_req, 0);
        chk("R1 det", det_flags, 0);
        chk("R1 rxo", rxo_valid, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 post req", ins_req, 0);
        fc_enable = 1;

        // R2 R3 R4 sweep: receive modes x codes
        exp_pause = 0;
        for (int m = 0; m < 4; m++) begin
            fc_mode = 4'(m);
            for (int i = 0; i < 5; i++) begin
                bit hit;
                hit = (i < 4) && ((i == 0 || i == 2) ? m[1] : m[0]);
                rx_valid = 1; rx_char = code_of(i);
                @(negedge clk);
                rx_valid = 0;
                if (hit) exp_pause = (i >= 2);
                chk("R2 det", det_flags, hit ? (1 << i) : 0);
                chk("R3 pause", tx_pause, exp_pause);
                chk("R4 fwd", rxo_valid, !hit);
                if (!hit) chk("R4 char", rxo_char, code_of(i));
                @(negedge clk);
                chk("R4 single", rxo_valid, 0);
            end
        end

        // R9 disable: pause cleared, codes forwarded
        rx_valid = 1; rx_char = xoff1_code; @(negedge clk); rx_valid = 0;
        chk("R3 pause set", tx_pause, 1);
        fc_enable = 0;
        rx_valid = 1; rx_char = xoff2_code; @(negedge clk); rx_valid = 0;
        chk("R9 det", det_flags, 0);
        chk("R9 fwd", rxo_valid, 1);
        chk("R9 pause", tx_pause, 0);
        fc_enable = 1;
        @(negedge clk);

        // R5 R6 R7 R8 sweep over transmit modes
        for (int g = 0; g < 4; g++) begin
            fc_mode = 4'(g << 2);
            for (int ph = 0; ph < 2; ph++) begin
                int n;
                fifo_level = (ph == 0) ? 8'd40 : 8'd8;
                @(negedge clk);
                n = (g == 3) ? 2 : (g == 0 ? 0 : 1);
                if (n == 0) begin
                    chk("R5 mode00 idle", ins_req, 0);
                    continue;
                end
                for (int s = 0; s < n; s++) begin
                    int idx;
                    idx = (ph == 0 ? 2 : 0) + ((g == 1 || s == 1) ? 1 : 0);
                    chk(ph == 0 ? "R5 req" : "R6 req", ins_req, 1);
                    chk(s == 1 ? "R7 order" : (ph == 0 ? "R5 code" : "R6 code"), ins_char, code_of(idx));
                    @(negedge clk);
                    chk("R8 hold", ins_char, code_of(idx));
                    ins_ready = 1;
                    @(negedge clk);
                    ins_ready = 0;
                end
                chk("R7 end", ins_req, 0);
                repeat (3) @(negedge clk);
                chk("R8 once", ins_req, 0);
            end
        end

        // R9: disable aborts pending request
        fc_mode = 4'b1000; fifo_level = 8'd40;
        @(negedge clk);
        chk("R5 req again", ins_req, 1);
        fc_enable = 0;
        @(negedge clk);
        chk("R9 req", ins_req, 0);
        finish_run();
    end
endmodule